// File: doc/BRIEF.md
# Quad Converter Parallel Register Front End

This block is the digital front end of a bank of four 14-bit converters. A host writes 14-bit words over an asynchronous parallel bus. The bus has an active-low chip select, an active-low write strobe and a 3-bit address. Each transfer lands in one of five data registers: four per-channel registers and one shared broadcast register. The block drives one 14-bit code per channel, and a channel's code follows its register as soon as a new word arrives. No separate load step is needed.

Two level-sensitive overrides sit between the stored registers and the channel codes. A broadcast select input makes every channel show the broadcast register. An asynchronous active-low clear forces every channel to the zero-volt code. Neither override alters any stored register, so the outputs return to their earlier values when the override is dropped.

The block runs on a system clock. Chip select, write strobe and broadcast select pass through synchronisers. A write is taken on the rising edge of the synchronised strobe, and address and data are sampled in that same cycle. Codes are offset binary: 0x0000 is negative full scale, 0x3FFF is positive full scale and 0x2000 is the midpoint.

Top module: `quad_dac_regif`

## Requirements
- R1: After reset all four channel codes read 0x2000, and the broadcast register also holds 0x2000.
- R2: A write with address 0, 1, 2 or 3 stores the 14-bit bus word into channel 0, 1, 2 or 3. Bus bit 13 becomes code bit 13, and only that channel's code changes.
- R3: While chip select is high, a write strobe pulse changes no register and no output.
- R4: A word is taken only when the write strobe rises. While the strobe is held low, the outputs keep their previous values.
- R5: Address 4 writes the broadcast register. With broadcast select low, this write leaves all channel codes unchanged.
- R6: While broadcast select is high, all four codes equal the broadcast register. When select falls, each code returns to its own channel register.
- R7: Addresses 5, 6 and 7 are ignored. A write to them changes neither the channel registers nor the broadcast register.
- R8: While clear is low, every code is 0x2000 at once, with no clock edge needed. On release, each code returns to its register, or to the broadcast register if select is high. Writes made during clear are kept.
- R9: With inputs driven midway between clock edges, a written word appears on its channel after the fourth rising clock edge that follows the strobe's rise, and not after the third.
- R10: Writes made while broadcast select is high still update the channel registers. A write to the broadcast register updates all four codes at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select (asynchronous) |
| wrN | input | 1 | Active-low write strobe; a word is taken on its rising edge |
| addr | input | 3 | Register address: 0-3 channels, 4 broadcast, 5-7 ignored |
| dataIn | input | 14 | Bus word, bit 13 is the MSB |
| selBcast | input | 1 | High routes the broadcast register to all channels |
| clrN | input | 1 | Asynchronous active-low clear to the midpoint code |
| chanCode | output | 56 | Channel codes; channel c occupies bits [14c+13:14c] |

## Verification
The bench builds the block with its default four channels, 14-bit words and two-stage synchronisers. At that size it can sweep a walking one through every bit of every channel register, and also load all-zeros, all-ones and a channel-specific word. An arithmetic model of the five registers predicts every code after each write. With two synchroniser stages the write latency is exactly four edges, so the bench can pin R9 to a single cycle. The small address space lets every ignored address and every combination of select and clear be tried against stored contents that differ per channel.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  localparam int CH_N    = 4;
  localparam int DATA_W  = 14;
  localparam int ADDR_W  = 3;
  localparam int REG_N   = CH_N + 1;
  localparam int BC_IDX  = CH_N;
  localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(1) << (DATA_W - 1);

  typedef struct packed {
    logic [REG_N-1:0] load;
    logic             bcast;
  } qdr_strobe_t;
endpackage

// File: rtl/qdr_ctrl.sv
module qdr_ctrl
  import qdr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              wrN,
  input  logic              selBcast,
  input  logic [ADDR_W-1:0] addr,
  output qdr_strobe_t       strb
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] csSync;
  logic [SYNC_STAGES-1:0] wrSync;
  logic [SYNC_STAGES-1:0] selSync;
  logic wrLast;
  logic csLast;
  logic wrRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSync  <= '1;
      wrSync  <= '1;
      selSync <= '0;
      wrLast  <= 1'b1;
      csLast  <= 1'b1;
    end else begin
      csSync  <= {csSync[TOP-1:0], csN};
      wrSync  <= {wrSync[TOP-1:0], wrN};
      selSync <= {selSync[TOP-1:0], selBcast};
      wrLast  <= wrSync[TOP];
      csLast  <= csSync[TOP];
    end
  end

  // strobe was low and chip selected one cycle ago, strobe high now
  assign wrRise = wrSync[TOP] && !wrLast && !csLast;

  generate
    for (genvar r = 0; r < REG_N; r++) begin : g_dec
      assign strb.load[r] = wrRise && (addr == ADDR_W'(r));
    end
  endgenerate

  assign strb.bcast = selSync[TOP];
endmodule

// File: rtl/qdr_datapath.sv
module qdr_datapath
  import qdr_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     clrN,
  input  logic [DATA_W-1:0]        dataIn,
  input  qdr_strobe_t              strb,
  output logic [CH_N*DATA_W-1:0]   chanFlat
);
  logic [DATA_W-1:0] regQ  [REG_N];
  logic [DATA_W-1:0] outQ  [CH_N];

  generate
    for (genvar r = 0; r < REG_N; r++) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             regQ[r] <= MID_CODE;
        else if (strb.load[r]) regQ[r] <= dataIn;
      end
    end

    for (genvar c = 0; c < CH_N; c++) begin : g_out
      always_ff @(posedge clk or negedge rstN or negedge clrN) begin
        if (!rstN || !clrN) outQ[c] <= MID_CODE;
        else                outQ[c] <= strb.bcast ? regQ[BC_IDX] : regQ[c];
      end
      assign chanFlat[c*DATA_W +: DATA_W] = outQ[c];
    end
  endgenerate
endmodule

// File: rtl/quad_dac_regif.sv
module quad_dac_regif
  import qdr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   csN,
  input  logic                   wrN,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      dataIn,
  input  logic                   selBcast,
  input  logic                   clrN,
  output logic [CH_N*DATA_W-1:0] chanCode
);
  qdr_strobe_t strb;

  qdr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .csN      (csN),
    .wrN      (wrN),
    .selBcast (selBcast),
    .addr     (addr),
    .strb     (strb)
  );

  qdr_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .clrN     (clrN),
    .dataIn   (dataIn),
    .strb     (strb),
    .chanFlat (chanCode)
  );
endmodule

// File: rtl/qdr_checker.sv
module qdr_checker
  import qdr_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   clrN,
  input logic                   wrN,
  input logic                   selBcast,
  input logic [CH_N*DATA_W-1:0] chanCode
);
  logic [2:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
  end

  function automatic logic allMid(input logic [CH_N*DATA_W-1:0] v);
    logic ok = 1'b1;
    for (int c = 0; c < CH_N; c++)
      if (v[c*DATA_W +: DATA_W] != MID_CODE) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic allSame(input logic [CH_N*DATA_W-1:0] v);
    logic ok = 1'b1;
    for (int c = 1; c < CH_N; c++)
      if (v[c*DATA_W +: DATA_W] != v[DATA_W-1:0]) ok = 1'b0;
    return ok;
  endfunction

  // R1: first edge after reset release still shows the midpoint
  p_reset_mid_r1: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 3'd0) |-> allMid(chanCode));

  // R8: clear forces every channel to the midpoint
  p_clear_mid_r8: assert property (@(posedge clk) disable iff (!rstN)
    !clrN |-> allMid(chanCode));

  // R6: select held long enough makes all channels identical
  p_sel_uniform_r6: assert property (@(posedge clk) disable iff (!rstN || !clrN)
    (sinceRst >= 3'd4 && selBcast && $past(selBcast, 1) && $past(selBcast, 2)
     && $past(selBcast, 3)) |-> allSame(chanCode));

  // R4: with no strobe, select or clear activity the codes hold
  p_hold_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'd6 && clrN && $past(clrN, 1) && $past(clrN, 2)
     && wrN == $past(wrN, 1) && wrN == $past(wrN, 2) && wrN == $past(wrN, 3)
     && wrN == $past(wrN, 4) && wrN == $past(wrN, 5)
     && selBcast == $past(selBcast, 1) && selBcast == $past(selBcast, 2)
     && selBcast == $past(selBcast, 3) && selBcast == $past(selBcast, 4))
    |-> $stable(chanCode));
endmodule

bind quad_dac_regif qdr_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .clrN     (clrN),
  .wrN      (wrN),
  .selBcast (selBcast),
  .chanCode (chanCode)
);

// File: tb/quad_dac_regif_bench.sv
module quad_dac_regif_bench;
  localparam int CH = 4;
  localparam int W  = 14;
  localparam logic [W-1:0] MID = 14'h2000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic wrN = 1'b1;
  logic [2:0] addr = '0;
  logic [W-1:0] dataIn = '0;
  logic selBcast = 1'b0;
  logic clrN = 1'b1;
  logic [CH*W-1:0] chanCode;

  logic [W-1:0] mdl [5];
  int total = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  quad_dac_regif u_quad_dac_regif (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .addr(addr),
    .dataIn(dataIn), .selBcast(selBcast), .clrN(clrN), .chanCode(chanCode)
  );

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int c, input logic [W-1:0] exp);
    logic [W-1:0] got;
    got = chanCode[c*W +: W];
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s ch%0d got %h expected %h", tag, c, got, exp);
    end
  endtask

  function automatic logic [W-1:0] expOf(input int c);
    if (!clrN) return MID;
    if (selBcast) return mdl[4];
    return mdl[c];
  endfunction

  task automatic checkAll(input string tag);
    for (int c = 0; c < CH; c++) chk(tag, c, expOf(c));
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [W-1:0] d, input logic csLvl);
    addr = a; dataIn = d; csN = csLvl;
    waitN(2);
    wrN = 1'b0;
    waitN(3);
    wrN = 1'b1;
    waitN(6);
    csN = 1'b1;
    if (!csLvl && a < 3'd5) mdl[a] = d;
  endtask

  initial begin
    for (int r = 0; r < 5; r++) mdl[r] = MID;
    waitN(5);
    rstN = 1'b1;
    waitN(6);
    checkAll("R1");
    selBcast = 1'b1; waitN(6);
    checkAll("R1 broadcast reg");
    selBcast = 1'b0; waitN(6);

    // R2: walking one, extremes and distinct word per channel
    for (int c = 0; c < CH; c++) begin
      for (int b = 0; b < W; b++) begin
        writeReg(3'(c), W'(1) << b, 1'b0);
        checkAll("R2 walk");
      end
      writeReg(3'(c), 14'h0000, 1'b0); checkAll("R2 zero");
      writeReg(3'(c), 14'h3FFF, 1'b0); checkAll("R2 ones");
      writeReg(3'(c), 14'(c * 14'h0F0F + 14'h0123), 1'b0); checkAll("R2 word");
    end

    writeReg(3'd4, 14'h3A5C, 1'b0);
    checkAll("R5");

    writeReg(3'd0, 14'h0001, 1'b1);
    checkAll("R3");

    for (int a = 5; a < 8; a++) begin
      writeReg(3'(a), 14'h0777, 1'b0);
      checkAll("R7");
    end
    selBcast = 1'b1; waitN(6);
    checkAll("R7 broadcast kept");
    checkAll("R6 select");
    selBcast = 1'b0; waitN(6);
    checkAll("R6 release");

    selBcast = 1'b1; waitN(6);
    writeReg(3'd1, 14'h1234, 1'b0);
    checkAll("R10 chan write under select");
    writeReg(3'd4, 14'h0F0F, 1'b0);
    checkAll("R10 broadcast update");
    selBcast = 1'b0; waitN(6);
    checkAll("R10 release");

    // R4: strobe held low keeps outputs
    addr = 3'd2; dataIn = 14'h1111; csN = 1'b0;
    waitN(2); wrN = 1'b0; waitN(12);
    checkAll("R4 strobe low");
    wrN = 1'b1; waitN(6); csN = 1'b1; mdl[2] = 14'h1111;
    checkAll("R4 after rise");

    // R9: exact latency
    addr = 3'd3; dataIn = 14'h2B2B; csN = 1'b0;
    waitN(2); wrN = 1'b0; waitN(3); wrN = 1'b1;
    waitN(3);
    checkAll("R9 third edge");
    waitN(1);
    mdl[3] = 14'h2B2B;
    checkAll("R9 fourth edge");
    waitN(4); csN = 1'b1;

    // R8: asynchronous clear
    clrN = 1'b0; #1;
    checkAll("R8 async");
    writeReg(3'd0, 14'h0ABC, 1'b0);
    checkAll("R8 held");
    clrN = 1'b1; waitN(2);
    checkAll("R8 release");
    selBcast = 1'b1; waitN(6);
    clrN = 1'b0; #1;
    checkAll("R8 async select");
    waitN(2); clrN = 1'b1; waitN(2);
    checkAll("R8 release select");
    selBcast = 1'b0; waitN(6);
    checkAll("R8 final");

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule